// File: doc/BRIEF.md
# Mode-Aware Display Sync Timing Generator

This block walks a raster of visible pixels and lines from a pixel clock and produces the horizontal and vertical retrace pulses, a blanking flag and the current pixel and line positions. By default the raster is 640x480 with 800 clocks per line and 525 lines per frame. Each phase of the scan is a parameter: the visible span, the porch ahead of the pulse, the pulse itself and the porch after it.

The two retrace outputs are then shaped by the attached display type and the monitor power state. A cathode-ray monitor uses a polarity that is chosen for each pulse. A flat TFT panel or a double-scan panel gets active-low pulses, which mark the 640x480 resolution. A passive LCD with no CRT attached gets both outputs held low. A two-bit power-management state can stop either pulse, or both, at its idle level.

The display type and the two polarity bits are captured only on the last clock of a frame. A change therefore never alters a pulse partway through a frame. The power state acts at once.

Top module: `crt_sync_gen`

## Requirements
- R1: `pix_x` counts 0 to H_TOT-1 and wraps to 0. `line_y` advances by one on each wrap of `pix_x` and wraps to 0 after V_TOT-1. H_TOT is the sum of the four horizontal parameters and V_TOT is the sum of the four vertical ones.
- R2: `blank` is 1 exactly when `pix_x` >= H_VIS or `line_y` >= V_VIS, whatever the display type.
- R3: The horizontal pulse is asserted while `pix_x` lies in [H_VIS+H_FP, H_VIS+H_FP+H_SYNC). The vertical pulse is asserted on every clock of the lines in [V_VIS+V_FP, V_VIS+V_FP+V_SYNC). In CRT type with a polarity bit of 1, the asserted level is 1.
- R4: Display type 2'b00 (CRT) takes each pulse's polarity from its own bit, `hs_pol` or `vs_pol`. A bit of 1 means active-high and a bit of 0 means active-low.
- R5: Display types 2'b01 (TFT) and 2'b10 (double-scan) drive both pulses active-low whatever the polarity bits are.
- R6: Display type 2'b11 (LCD only) holds `hsync` and `vsync` at 0 in every power state.
- R7: Power state 2'b01 (standby) holds `hsync` at its inactive level while `vsync` keeps running.
- R8: Power state 2'b10 (suspend) holds `vsync` at its inactive level while `hsync` keeps running.
- R9: Power state 2'b11 (off) holds both pulses at their inactive levels. State 2'b00 (on) runs both. The power state takes effect in the same cycle it is applied.
- R10: `disp_mode`, `hs_pol` and `vs_pol` are sampled only at the clock edge that ends pixel (H_TOT-1, V_TOT-1). They govern the outputs from pixel (0,0) of the next frame. Changes at any other time have no effect until then.
- R11: While `rst_n` is low, both counters are 0 and the captured settings are LCD only with both polarity bits 0. As a result `hsync`, `vsync` and `blank` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_mode | input | 2 | Display type: 00 CRT, 01 TFT, 10 double-scan, 11 LCD only |
| hs_pol | input | 1 | CRT horizontal pulse polarity, 1 = active-high |
| vs_pol | input | 1 | CRT vertical pulse polarity, 1 = active-high |
| dpms | input | 2 | Power state: 00 on, 01 standby, 10 suspend, 11 off |
| hsync | output | 1 | Conditioned horizontal retrace pulse |
| vsync | output | 1 | Conditioned vertical retrace pulse |
| blank | output | 1 | High outside the visible region |
| pix_x | output | $clog2(H_TOT) | Current pixel in the line |
| line_y | output | $clog2(V_TOT) | Current line in the frame |

## Verification
Two events can land on the same edge: a new display type or polarity arrives on the very clock that closes a frame, and the power state changes in the middle of a retrace pulse. The bench changes the settings on the last pixel of many frames and at random points mid-frame. It expects the old settings to hold up to the frame boundary and the new ones to apply exactly from pixel (0,0). Power-state changes happen at random times, including inside the pulse windows. The expected level is computed from the power state present in the cycle being sampled, so a stop or restart must show in the very cycle it is applied.

// File: rtl/crt_sync_gen.sv
module crt_sync_gen #(
  parameter int H_VIS  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33,
  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP,
  localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP,
  localparam int XW    = $clog2(H_TOT),
  localparam int YW    = $clog2(V_TOT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    disp_mode,
  input  logic          hs_pol,
  input  logic          vs_pol,
  input  logic [1:0]    dpms,
  output logic          hsync,
  output logic          vsync,
  output logic          blank,
  output logic [XW-1:0] pix_x,
  output logic [YW-1:0] line_y
);

  localparam logic [XW-1:0] X_LAST = XW'(H_TOT - 1);
  localparam logic [YW-1:0] Y_LAST = YW'(V_TOT - 1);
  localparam logic [XW-1:0] X_VIS  = XW'(H_VIS);
  localparam logic [YW-1:0] Y_VIS  = YW'(V_VIS);
  localparam logic [XW-1:0] HS_BEG = XW'(H_VIS + H_FP);
  localparam logic [XW-1:0] HS_END = XW'(H_VIS + H_FP + H_SYNC);
  localparam logic [YW-1:0] VS_BEG = YW'(V_VIS + V_FP);
  localparam logic [YW-1:0] VS_END = YW'(V_VIS + V_FP + V_SYNC);
  localparam logic [1:0]    M_CRT  = 2'b00;
  localparam logic [1:0]    M_LCD  = 2'b11;

  logic [XW-1:0] h_cnt;
  logic [YW-1:0] v_cnt;
  logic [1:0]    mode_q;
  logic          hpol_q, vpol_q;

  wire line_end  = (h_cnt == X_LAST);
  wire frame_end = line_end && (v_cnt == Y_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_cnt  <= '0;
      v_cnt  <= '0;
      mode_q <= M_LCD;
      hpol_q <= 1'b0;
      vpol_q <= 1'b0;
    end else begin
      h_cnt <= line_end ? '0 : h_cnt + 1'b1;
      if (line_end)
        v_cnt <= (v_cnt == Y_LAST) ? '0 : v_cnt + 1'b1;
      if (frame_end) begin
        mode_q <= disp_mode;
        hpol_q <= hs_pol;
        vpol_q <= vs_pol;
      end
    end
  end

  wire h_act = (h_cnt >= HS_BEG) && (h_cnt < HS_END);
  wire v_act = (v_cnt >= VS_BEG) && (v_cnt < VS_END);
  wire h_run = h_act && !dpms[0];
  wire v_run = v_act && !dpms[1];
  wire is_crt = (mode_q == M_CRT);
  wire is_lcd = (mode_q == M_LCD);

  assign hsync  = !is_lcd && ((is_crt && hpol_q) ? h_run : !h_run);
  assign vsync  = !is_lcd && ((is_crt && vpol_q) ? v_run : !v_run);
  assign blank  = !((h_cnt < X_VIS) && (v_cnt < Y_VIS));
  assign pix_x  = h_cnt;
  assign line_y = v_cnt;

endmodule

// File: rtl/crt_sync_gen_chk.sv
module crt_sync_gen_chk #(
  parameter int H_TOT = 800,
  parameter int V_TOT = 525,
  localparam int XW = $clog2(H_TOT),
  localparam int YW = $clog2(V_TOT)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    dpms,
  input logic          hsync,
  input logic          vsync,
  input logic          blank,
  input logic [XW-1:0] pix_x,
  input logic [YW-1:0] line_y,
  input logic [1:0]    mode_q,
  input logic          hpol_q,
  input logic          vpol_q
);
  localparam logic [XW-1:0] X_LAST = XW'(H_TOT - 1);
  localparam logic [YW-1:0] Y_LAST = YW'(V_TOT - 1);

  assert_hwrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_x == X_LAST) |=> (pix_x == '0));
  assert_hstep_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_x != X_LAST) |=> (pix_x == XW'($past(pix_x) + 1'b1)));
  assert_blank_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(blank) |-> (pix_x == '0));
  assert_vs_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_x != X_LAST) |=> ((dpms != $past(dpms)) || (vsync == $past(vsync))));
  assert_standby_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b00 && dpms == 2'b01) |-> (hsync == !hpol_q));
  assert_lcd_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b11) |-> (!hsync && !vsync));
  assert_panel_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == 2'b01 || mode_q == 2'b10) && dpms == 2'b11) |-> (hsync && vsync));
  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(pix_x == X_LAST && line_y == Y_LAST) |=>
      ($stable(mode_q) && $stable(hpol_q) && $stable(vpol_q)));
endmodule

bind crt_sync_gen crt_sync_gen_chk #(.H_TOT(H_TOT), .V_TOT(V_TOT)) u_chk (
  .clk(clk), .rst_n(rst_n), .dpms(dpms), .hsync(hsync), .vsync(vsync),
  .blank(blank), .pix_x(pix_x), .line_y(line_y),
  .mode_q(mode_q), .hpol_q(hpol_q), .vpol_q(vpol_q)
);

// File: tb/crt_sync_gen_bench.sv
module crt_sync_gen_bench;
  localparam int HV = 8, HF = 2, HS = 3, HB = 2;
  localparam int VV = 4, VF = 1, VS = 2, VB = 1;
  localparam int HT = HV + HF + HS + HB;
  localparam int VT = VV + VF + VS + VB;
  localparam int XW = $clog2(HT);
  localparam int YW = $clog2(VT);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] disp_mode = 2'b00, dpms = 2'b00;
  logic hs_pol = 1'b0, vs_pol = 1'b0;
  logic hsync, vsync, blank;
  logic [XW-1:0] pix_x;
  logic [YW-1:0] line_y;

  int tests = 0, fails = 0;
  bit done = 1'b0;
  int mx = 0, my = 0;
  logic [1:0] mmode = 2'b11;
  logic mhp = 1'b0, mvp = 1'b0;

  always #5 clk = ~clk;

  crt_sync_gen #(.H_VIS(HV), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
                 .V_VIS(VV), .V_FP(VF), .V_SYNC(VS), .V_BP(VB)) u_crt_sync_gen (
    .clk(clk), .rst_n(rst_n), .disp_mode(disp_mode), .hs_pol(hs_pol),
    .vs_pol(vs_pol), .dpms(dpms), .hsync(hsync), .vsync(vsync),
    .blank(blank), .pix_x(pix_x), .line_y(line_y));

  function automatic logic exp_level(logic act, logic stop, logic [1:0] m, logic p);
    logic run;
    run = act && !stop;
    if (m == 2'b11) return 1'b0;
    if (m == 2'b00) return p ? run : !run;
    return !run;
  endfunction

  function automatic string pick_tag(logic is_h);
    if (disp_mode != mmode) return "R10";
    if (mmode == 2'b11) return "R6";
    if (dpms == 2'b01) return is_h ? "R7" : "R9";
    if (dpms == 2'b10) return is_h ? "R9" : "R8";
    if (dpms == 2'b11) return "R9";
    if (mmode != 2'b00) return "R5";
    return (is_h ? mhp : mvp) ? "R3" : "R4";
  endfunction

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d (x=%0d y=%0d)", tag, act, exp, mx, my);
    end
  endtask

  task automatic check_all();
    logic ha, va;
    ha = (mx >= HV + HF) && (mx < HV + HF + HS);
    va = (my >= VV + VF) && (my < VV + VF + VS);
    chk("R1 x", int'(pix_x), mx);
    chk("R1 y", int'(line_y), my);
    chk("R2 blank", int'(blank), int'(mx >= HV || my >= VV));
    chk({pick_tag(1'b1), " hsync"}, int'(hsync), int'(exp_level(ha, dpms[0], mmode, mhp)));
    chk({pick_tag(1'b0), " vsync"}, int'(vsync), int'(exp_level(va, dpms[1], mmode, mvp)));
  endtask

  task automatic advance_model();
    if (mx == HT - 1 && my == VT - 1) begin
      mmode = disp_mode; mhp = hs_pol; mvp = vs_pol;
    end
    if (mx == HT - 1) begin
      mx = 0;
      my = (my == VT - 1) ? 0 : my + 1;
    end else mx = mx + 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    disp_mode = 2'b01; hs_pol = 1'b1; vs_pol = 1'b1;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 x", int'(pix_x), 0);
    chk("R11 y", int'(line_y), 0);
    chk("R11 hsync", int'(hsync), 0);
    chk("R11 vsync", int'(vsync), 0);
    chk("R11 blank", int'(blank), 0);
    rst_n = 1'b1;
    check_all();
    for (int i = 0; i < 40 * HT * VT; i++) begin
      if (mx == HT - 1 && my == VT - 1) begin
        // corner: settings arrive on the frame-closing clock
        if ($urandom_range(1, 0) == 1) begin
          disp_mode = 2'($urandom_range(3, 0));
          hs_pol = 1'($urandom_range(1, 0));
          vs_pol = 1'($urandom_range(1, 0));
        end
      end else if ($urandom_range(19, 0) == 0) begin
        disp_mode = 2'($urandom_range(3, 0));
        hs_pol = 1'($urandom_range(1, 0));
        vs_pol = 1'($urandom_range(1, 0));
      end
      if ((mx == HV + HF + 1) || $urandom_range(29, 0) == 0)
        dpms = 2'($urandom_range(3, 0));
      if (i > 30 * HT * VT) dpms = 2'b00;
      advance_model();
      @(negedge clk);
      check_all();
    end
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule